// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns the demodulated, active-low output of an infrared receiver into an 8-bit address and an 8-bit command. It watches only the falling edges of the line. At each falling edge it takes the current value of a tick counter as the length of the interval that just ended, and then restarts the counter from zero. A programmable clock divider sets the tick rate, so one tick lasts 8 µs at any system clock. Each interval is reduced at once to one bit: long means 1, short means 0. The bits are kept in arrival order.

When the last edge of a frame arrives, the block assembles the two fields and loads them onto its outputs. It then locks, and ignores further edges until the line has been quiet long enough for the tick counter to wrap. The same wrap discards a partial frame, which puts the block back in step with the remote. A second output holds the last distinct code. It changes, together with a one-cycle strobe, only when a decoded address/command pair differs from the one already shown.

Top module: `ir_frame_decoder`

## Requirements
- R1: After synchronous reset, `addr_o`, `cmd_o` and `shown_code_o` are zero and `new_code_o` is low. The stored bits, the edge count and the lock are also cleared.
- R2: Only falling edges of `ir_rx_n` start a measurement. The value taken at each falling edge is the number of ticks since the previous falling edge. Rising edges neither capture a value nor restart the count.
- R3: An interval of more than `ONE_ABOVE` ticks (default 240) is read as a 1. An interval of exactly `ONE_ABOVE` ticks, or fewer, is read as a 0.
- R4: Intervals are numbered from 0, starting with the first captured edge of a frame. `addr_o` is built from intervals 2 to 9 and `cmd_o` from intervals 18 to 25. In each field the lowest-numbered interval supplies bit 0.
- R5: The frame is complete at the 34th captured edge (`EDGES`). `addr_o` and `cmd_o` load on the third rising clock edge after the line falls for that edge, which counts two synchroniser stages and the capture register.
- R6: After a decode the block is locked. While it is locked, falling edges change no output and do not start a new frame, but each one still restarts the tick counter.
- R7: When the tick counter wraps past its maximum (2^`TIMER_W` ticks with no falling edge), the lock is released and any partial frame is discarded. The next falling edge then becomes interval 0.
- R8: If a newly loaded address/command pair differs from `shown_code_o`, then on the next clock edge `shown_code_o` takes the pair (address in bits 15:8, command in bits 7:0) and `new_code_o` is high for exactly one cycle.
- R9: If a decoded pair equals `shown_code_o`, then `new_code_o` stays low and `shown_code_o` does not change, although `addr_o` and `cmd_o` still load.
- R10: The tick counter advances once every `TICK_DIV` clock cycles, counted from the last captured edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_rx_n | input | 1 | Demodulated receiver line, active low, asynchronous |
| addr_o | output | 8 | Address from the most recent decode |
| cmd_o | output | 8 | Command from the most recent decode |
| new_code_o | output | 1 | One-cycle strobe when the shown code changes |
| shown_code_o | output | 16 | Last distinct code, {address, command} |

## Verification
The bench drives the line on falling clock edges and samples on falling clock edges, so each result falls in a fixed cycle. The decoded fields must appear after three rising edges counted from the final falling drive. The strobe and the shown code must follow one rising edge later, and the strobe must be gone one edge after that. The bench checks each of these in its own exact cycle. Suppressed decodes are checked in the same cycles, and a negedge counter of strobes confirms that none fired at any time in between. Intervals are set in whole clock cycles, so with a divider of 2 the tick values 240 and 241 can be placed exactly on either side of the threshold.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;
  localparam int IR_FIELD_W = 8;

  typedef struct packed {
    logic [IR_FIELD_W-1:0] addr;
    logic [IR_FIELD_W-1:0] cmd;
  } ir_code_t;
endpackage

// File: rtl/ir_edge_sync.sv
module ir_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_n,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall = prev_q & ~sync_q;

  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/ir_interval_timer.sv
module ir_interval_timer #(
  parameter int TICK_DIV = 32,
  parameter int TIMER_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  output logic [TIMER_W-1:0] count,
  output logic               wrap
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0]   div_q;
  logic [TIMER_W-1:0] count_q;
  logic               tick;

  assign tick  = (div_q == DIV_W'(TICK_DIV - 1));
  assign wrap  = tick && (count_q == '1) && !clear;
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q   <= '0;
      count_q <= '0;
    end else if (tick) begin
      div_q   <= '0;
      count_q <= count_q + 1'b1;
    end else begin
      div_q   <= div_q + 1'b1;
    end
  end

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> count_q == '0);
  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> count_q == '0);
endmodule

// File: rtl/ir_frame_capture.sv
module ir_frame_capture
  import ir_dec_pkg::*;
#(
  parameter int TIMER_W   = 16,
  parameter int EDGES     = 34,
  parameter int ONE_ABOVE = 240,
  parameter int ADDR_POS  = 2,
  parameter int CMD_POS   = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fall,
  input  logic               wrap,
  input  logic [TIMER_W-1:0] interval,
  output ir_code_t           code,
  output logic               load
);
  localparam int CNT_W = $clog2(EDGES + 1);

  logic [EDGES-1:0] bits_q, bits_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             locked_q, load_q, cur_one, take, last;
  ir_code_t         code_q;

  assign cur_one = interval > TIMER_W'(ONE_ABOVE);
  assign take    = fall && !locked_q;
  assign last    = (cnt_q == CNT_W'(EDGES - 1));

  for (genvar i = 0; i < EDGES; i++) begin : g_slot
    assign bits_nx[i] = (cnt_q == CNT_W'(i)) ? cur_one : bits_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q   <= '0;
      cnt_q    <= '0;
      locked_q <= 1'b0;
      load_q   <= 1'b0;
      code_q   <= '0;
    end else begin
      load_q <= 1'b0;
      if (take) begin
        bits_q <= bits_nx;
        if (last) begin
          cnt_q       <= '0;
          locked_q    <= 1'b1;
          load_q      <= 1'b1;
          code_q.addr <= bits_nx[ADDR_POS +: IR_FIELD_W];
          code_q.cmd  <= bits_nx[CMD_POS +: IR_FIELD_W];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (wrap) begin
        cnt_q    <= '0;
        locked_q <= 1'b0;
      end
    end
  end

  assign code = code_q;
  assign load = load_q;

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(EDGES));
  // R6
  lock_idle_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |-> cnt_q == '0);
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q && !wrap |=> locked_q && $stable(code_q));
  // R7
  wrap_release_chk: assert property (@(posedge clk) disable iff (rst)
    wrap && !fall |=> !locked_q && cnt_q == '0);
  // R5
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    load_q |=> !load_q);
endmodule

// File: rtl/ir_code_latch.sv
module ir_code_latch
  import ir_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  ir_code_t code,
  output ir_code_t shown,
  output logic     strobe
);
  ir_code_t shown_q;
  logic     strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shown_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (load && (code != shown_q)) begin
        shown_q  <= code;
        strobe_q <= 1'b1;
      end
    end
  end

  assign shown  = shown_q;
  assign strobe = strobe_q;

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);
  // R8
  shown_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (shown_q != $past(shown_q)) |-> strobe_q);
  // R9
  strobe_change_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> (shown_q != $past(shown_q)));
endmodule

// File: rtl/ir_frame_decoder.sv
module ir_frame_decoder
  import ir_dec_pkg::*;
#(
  parameter int TICK_DIV  = 32,
  parameter int TIMER_W   = 16,
  parameter int EDGES     = 34,
  parameter int ONE_ABOVE = 240,
  parameter int ADDR_POS  = 2,
  parameter int CMD_POS   = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ir_rx_n,
  output logic [IR_FIELD_W-1:0]   addr_o,
  output logic [IR_FIELD_W-1:0]   cmd_o,
  output logic                    new_code_o,
  output logic [2*IR_FIELD_W-1:0] shown_code_o
);
  logic               fall, wrap, load;
  logic [TIMER_W-1:0] interval;
  ir_code_t           code, shown;

  ir_edge_sync u_sync (
    .clk(clk), .rst(rst), .line_n(ir_rx_n), .fall(fall)
  );

  ir_interval_timer #(.TICK_DIV(TICK_DIV), .TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst(rst), .clear(fall), .count(interval), .wrap(wrap)
  );

  ir_frame_capture #(
    .TIMER_W(TIMER_W), .EDGES(EDGES), .ONE_ABOVE(ONE_ABOVE),
    .ADDR_POS(ADDR_POS), .CMD_POS(CMD_POS)
  ) u_cap (
    .clk(clk), .rst(rst), .fall(fall), .wrap(wrap), .interval(interval),
    .code(code), .load(load)
  );

  ir_code_latch u_latch (
    .clk(clk), .rst(rst), .load(load), .code(code),
    .shown(shown), .strobe(new_code_o)
  );

  assign addr_o       = code.addr;
  assign cmd_o        = code.cmd;
  assign shown_code_o = shown;
endmodule

// File: tb/sim_ir_frame_decoder.sv
module sim_ir_frame_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int ONE_CYC    = 600;  // 299 ticks
  localparam int ZERO_CYC   = 150;  // 74 ticks
  localparam int IDLE_CYC   = 3000; // > 1024 ticks * 2

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir  = 1'b1;
  logic [7:0]  addr_o, cmd_o;
  logic        new_code_o;
  logic [15:0] shown_code_o;

  int checks = 0, fails = 0, strobes = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_frame_decoder #(.TICK_DIV(2), .TIMER_W(10)) u0 (
    .clk(clk), .rst(rst), .ir_rx_n(ir),
    .addr_o(addr_o), .cmd_o(cmd_o), .new_code_o(new_code_o),
    .shown_code_o(shown_code_o)
  );

  always @(negedge clk) if (!rst && new_code_o) strobes++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // gap in cycles before edge e of a frame
  function automatic int gap_for(input int e, input logic [7:0] a, input logic [7:0] c,
                                 input int one_c, input int zero_c);
    if (e == 1) return ONE_CYC;
    if (e >= 2 && e <= 9) return a[e-2] ? one_c : zero_c;
    if (e >= 18 && e <= 25) return c[e-18] ? one_c : zero_c;
    return zero_c;
  endfunction

  task automatic send_edges(input int n, input int gap);
    for (int e = 0; e < n; e++) begin
      @(negedge clk); ir = 1'b0;
      idle(10); ir = 1'b1;
      idle(gap - 11);
    end
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] c,
                            input int one_c, input int zero_c,
                            input logic [7:0] ea, input logic [7:0] ec,
                            input bit exp_new, input logic [15:0] exp_shown,
                            input string tag);
    int s0;
    for (int e = 0; e < 34; e++) begin
      if (e > 0) idle(gap_for(e, a, c, one_c, zero_c) - 11);
      @(negedge clk); ir = 1'b0;
      if (e == 33) begin
        s0 = strobes;
        idle(3);
        chk(addr_o == ea, {tag, " R4 R5 address"}, addr_o, ea);
        chk(cmd_o == ec,  {tag, " R4 R5 command"}, cmd_o, ec);
        chk(new_code_o == 1'b0, {tag, " R8 no early strobe"}, new_code_o, 0);
        idle(1);
        chk(new_code_o == exp_new, {tag, " R8 R9 strobe"}, new_code_o, exp_new);
        chk(shown_code_o == exp_shown, {tag, " R8 R9 shown"}, shown_code_o, exp_shown);
        idle(1);
        chk(new_code_o == 1'b0, {tag, " R8 strobe width"}, new_code_o, 0);
        chk(strobes - s0 == int'(exp_new), {tag, " R9 strobe count"}, strobes - s0, int'(exp_new));
        idle(7);
      end else begin
        idle(10);
      end
      ir = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk(addr_o == 8'h00, "R1 addr reset", addr_o, 0);
    chk(cmd_o == 8'h00, "R1 cmd reset", cmd_o, 0);
    chk(shown_code_o == 16'h0, "R1 shown reset", shown_code_o, 0);
    chk(new_code_o == 1'b0, "R1 strobe reset", new_code_o, 0);
  endtask

  task automatic t_lock;
    int s0 = strobes;
    // second frame while locked: every edge ignored (R6)
    send_frame(8'h11, 8'h22, ONE_CYC, ZERO_CYC, 8'hA5, 8'h3C, 1'b0, 16'hA53C, "locked");
    chk(strobes == s0, "R6 no strobe while locked", strobes, s0);
    idle(IDLE_CYC);
  endtask

  task automatic t_partial;
    send_edges(20, ZERO_CYC);
    idle(IDLE_CYC); // wrap discards the partial frame (R7)
    send_frame(8'h5A, 8'hC3, ONE_CYC, ZERO_CYC, 8'h5A, 8'hC3, 1'b1, 16'h5AC3, "R7 resync");
    idle(IDLE_CYC);
  endtask

  task automatic t_boundary;
    // 483 cycles -> 241 ticks (one), 481 cycles -> 240 ticks (zero): R3 R10 R2
    send_frame(8'h96, 8'h69, 483, 481, 8'h96, 8'h69, 1'b1, 16'h9669, "R3 R10 threshold");
    idle(IDLE_CYC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(5);
    send_frame(8'hA5, 8'h3C, ONE_CYC, ZERO_CYC, 8'hA5, 8'h3C, 1'b1, 16'hA53C, "first");
    t_lock();
    send_frame(8'hA5, 8'h3C, ONE_CYC, ZERO_CYC, 8'hA5, 8'h3C, 1'b0, 16'hA53C, "R9 repeat");
    idle(IDLE_CYC);
    t_partial();
    t_boundary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule